// File: doc/BRIEF.md
# I2C Register Target With Write Checksum

This block is an I2C target that exposes a bank of 16-bit registers through an 8-bit register pointer. It recognises START and STOP on conditioned bus lines and answers only to one fixed 7-bit device address. A write carries the pointer and then two data bytes, high byte first. An extra checksum byte may follow the data, and the host side can make that checksum mandatory. A read takes one snapshot of the addressed register. It returns the high byte and then the low byte, and after those the bitwise inverse of each, so a bus master can verify what it received.

On the register side, a one-cycle write strobe carries the address and the full 16-bit value. A one-cycle read-sample strobe presents the address, and the register bank must return the data in that same cycle. SDA is driven as an open-drain output enable (`sda_oe` high pulls the line low). The pointer is never auto-incremented and survives between transactions, so a read may follow a write without sending the pointer again.

The controller is one state machine with these states:
- `ST_IDLE`: the bus is free.
- `ST_ADDR`: shifting in the device address byte.
- `ST_ADDR_ACK`: acknowledging that byte.
- `ST_RX`: shifting in a pointer, data or checksum byte.
- `ST_RX_ACK`: acknowledging that byte.
- `ST_TX`: shifting out a read byte.
- `ST_TX_ACK`: sampling the master's acknowledge.
- `ST_PARK`: not addressed, or a byte was refused; waiting for START or STOP.

Transitions:
- START from any state goes to `ST_ADDR`.
- STOP from any state goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on an address match and to `ST_PARK` otherwise.
- `ST_ADDR_ACK` goes to `ST_TX` for a read and to `ST_RX` for a write.
- `ST_RX` goes to `ST_RX_ACK` for an accepted byte and to `ST_PARK` for a refused byte.
- `ST_RX_ACK` goes back to `ST_RX`.
- `ST_TX` goes to `ST_TX_ACK`.
- `ST_TX_ACK` goes to `ST_TX` on a master ACK and to `ST_IDLE` on a NACK.

Top module: `i2c_chk_regslave`

## Requirements
- R1: The target acknowledges (drives SDA low during the ninth clock) only a first byte whose upper seven bits equal 1110011. For any other address it stays released for the rest of the transaction and issues neither strobe. Bit 0 of that byte selects the direction: 1 means read, 0 means write.
- R2: A write sends three bytes after the address byte: the register pointer, data bits 15:8, then data bits 7:0. Each byte is sent MSB first, and the target acknowledges each one.
- R3: With `chk_mode` low, a write that has delivered its low data byte is committed as a single one-cycle `wr_stb` carrying all 16 bits. The strobe is issued when the next STOP or repeated START is detected, and not before.
- R4: A fifth write byte equal to (0xFF + pointer + high byte + low byte) mod 256 is acknowledged. The register is committed at the start of that byte's acknowledge bit, before any STOP, and only once.
- R5: A fifth write byte that does not match this sum is not acknowledged, and the write is discarded, whatever the value of `chk_mode`.
- R6: With `chk_mode` high, a write that ends without a matching checksum byte is never committed.
- R7: A read issues exactly one `rd_stb` pulse while the read address byte is being acknowledged. The target then returns bits 15:8 and then bits 7:0 of that sample.
- R8: While the master keeps acknowledging, the next bytes are the inverse of the high byte and then the inverse of the low byte. They come from the same sample even if the register changes after sampling.
- R9: After the master NACKs a read byte, the target releases SDA and drives nothing more until a new START. It also leaves SDA released in the reset state and whenever it is idle or parked.
- R10: The register pointer does not auto-increment and keeps its last written value across transactions. A read with no pointer byte uses that value.
- R11: A START seen at any point abandons the transfer in progress, commits nothing that was incomplete, and restarts reception of the address byte.
- R12: The SDA output enable only rises in the cycle after an SCL falling edge has been detected on the conditioned lines. It only falls after an SCL falling edge, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| chk_mode | input | 1 | High makes the write checksum byte mandatory |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register pointer for the write |
| wr_data | output | 16 | Value to write |
| rd_stb | output | 1 | One-cycle register sample strobe |
| rd_addr | output | 8 | Register pointer for the sample |
| rd_data | input | 16 | Register value returned in the strobe cycle |

## Verification
The bench builds the block with its defaults: device address 1110011, two synchroniser stages and a three-sample filter. Against a bus quarter-period of twelve clocks, this filter settles well inside every SCL phase. Because the line conditioner is that short, the bench can sample the acknowledge bit mid-high and see the target release SDA before the master's next bit. It also puts the repeated-START commit, the checksum-ACK commit and the mid-byte abort within a few cycles of observable strobes. Random writes mix the three write forms with both settings of the mode input, and each is read back in full with the inverted echo.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

    localparam int RS_BYTE_W = 8;
    localparam int RS_AW     = 8;
    localparam int RS_DW     = 2 * RS_BYTE_W;
    localparam int RS_BCNT_W = $clog2(RS_BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_PARK
    } rs_state_e;

    // Additive write checksum, modulo 256
    function automatic logic [RS_BYTE_W-1:0] wr_checksum(
        input logic [RS_BYTE_W-1:0] ptr,
        input logic [RS_BYTE_W-1:0] hi,
        input logic [RS_BYTE_W-1:0] lo
    );
        logic [RS_BYTE_W-1:0] s;
        s = 8'hFF + ptr;
        s = s + hi;
        s = s + lo;
        return s;
    endfunction

    // Read byte order: high, low, ~high, ~low
    function automatic logic [RS_BYTE_W-1:0] rd_byte_sel(
        input logic [RS_DW-1:0] snap,
        input logic [1:0]       idx
    );
        logic [RS_BYTE_W-1:0] b;
        case (idx)
            2'd0:    b = snap[RS_DW-1:RS_BYTE_W];
            2'd1:    b = snap[RS_BYTE_W-1:0];
            2'd2:    b = ~snap[RS_DW-1:RS_BYTE_W];
            default: b = ~snap[RS_BYTE_W-1:0];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);

    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
        end
    end

    // New level is taken only after FILT_LEN consecutive differing samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            clean_o <= 1'b1;
        end else if (synced == clean_o) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            cnt_q   <= '0;
            clean_o <= synced;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int NLINES = 2;   // index 0 = SCL, 1 = SDA

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] clean;
    logic [NLINES-1:0] prev_q;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2c_glitch_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
        ) u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw[g]),
            .clean_o (clean[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= clean;
        end
    end

    assign sda_lvl   = clean[1];
    assign scl_rise  =  clean[0] & ~prev_q[0];
    assign scl_fall  = ~clean[0] &  prev_q[0];
    assign start_det =  clean[0] &  prev_q[0] &  prev_q[1] & ~clean[1];
    assign stop_det  =  clean[0] &  prev_q[0] & ~prev_q[1] &  clean[1];

endmodule

// File: rtl/i2c_chk_regslave.sv
module i2c_chk_regslave
    import i2c_rs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1110011,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             chk_mode,
    output logic             wr_stb,
    output logic [RS_AW-1:0] wr_addr,
    output logic [RS_DW-1:0] wr_data,
    output logic             rd_stb,
    output logic [RS_AW-1:0] rd_addr,
    input  logic [RS_DW-1:0] rd_data
);

    localparam logic [RS_BCNT_W-1:0] BYTE_BITS = RS_BCNT_W'(RS_BYTE_W);
    localparam logic [2:0]           IDX_CSUM  = 3'd3;
    localparam logic [2:0]           IDX_MAX   = 3'd7;

    logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    rs_state_e state_q, state_d;

    logic [RS_BCNT_W-1:0] bit_cnt_q;
    logic [RS_BYTE_W-1:0] rx_sr_q;
    logic [RS_BYTE_W-1:0] tx_sr_q;
    logic [RS_AW-1:0]     ptr_q;
    logic [RS_BYTE_W-1:0] hi_q;
    logic [RS_BYTE_W-1:0] lo_q;
    logic [2:0]           wr_idx_q;
    logic [1:0]           rd_idx_q;
    logic                 is_rd_q;
    logic                 mack_q;
    logic                 pend_q;
    logic [RS_DW-1:0]     snap_q;
    logic                 sda_oe_q;
    logic                 wr_stb_q;
    logic                 rd_stb_q;

    logic                 byte_end;
    logic                 addr_hit;
    logic                 csum_ok;
    logic                 rx_accept;
    logic [RS_BYTE_W-1:0] next_byte;
    logic                 st_quiet;

    i2c_line_cond #(
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_LEN    (FILT_LEN)
    ) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign byte_end  = scl_fall && (bit_cnt_q == BYTE_BITS);
    assign addr_hit  = (rx_sr_q[RS_BYTE_W-1:1] == DEV_ADDR);
    assign csum_ok   = (rx_sr_q == wr_checksum(ptr_q, hi_q, lo_q));
    assign rx_accept = (wr_idx_q < IDX_CSUM) || ((wr_idx_q == IDX_CSUM) && csum_ok);
    assign next_byte = rd_byte_sel(snap_q, rd_idx_q);
    assign st_quiet  = (state_q == ST_IDLE) || (state_q == ST_PARK);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_end) state_d = addr_hit ? ST_ADDR_ACK : ST_PARK;
                ST_ADDR_ACK: if (scl_fall) state_d = is_rd_q ? ST_TX : ST_RX;
                ST_RX:       if (byte_end) state_d = rx_accept ? ST_RX_ACK : ST_PARK;
                ST_RX_ACK:   if (scl_fall) state_d = ST_RX;
                ST_TX:       if (byte_end) state_d = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) state_d = mack_q ? ST_TX : ST_IDLE;
                ST_PARK:     state_d = ST_PARK;
            endcase
        end
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            rx_sr_q   <= '0;
            tx_sr_q   <= '0;
            ptr_q     <= '0;
            hi_q      <= '0;
            lo_q      <= '0;
            wr_idx_q  <= '0;
            rd_idx_q  <= '0;
            is_rd_q   <= 1'b0;
            mack_q    <= 1'b0;
            pend_q    <= 1'b0;
            snap_q    <= '0;
            sda_oe_q  <= 1'b0;
            wr_stb_q  <= 1'b0;
            rd_stb_q  <= 1'b0;
        end else begin
            wr_stb_q <= 1'b0;
            rd_stb_q <= 1'b0;
            if (rd_stb_q) begin
                snap_q <= rd_data;
            end
            if (start_det || stop_det) begin
                sda_oe_q  <= 1'b0;
                bit_cnt_q <= '0;
                if (pend_q) begin
                    wr_stb_q <= 1'b1;
                    pend_q   <= 1'b0;
                end
                if (start_det) begin
                    wr_idx_q <= '0;
                    rd_idx_q <= '0;
                end
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise && (bit_cnt_q != BYTE_BITS)) begin
                            rx_sr_q   <= {rx_sr_q[RS_BYTE_W-2:0], sda_lvl};
                            bit_cnt_q <= bit_cnt_q + RS_BCNT_W'(1);
                        end else if (byte_end) begin
                            bit_cnt_q <= '0;
                            if (state_q == ST_ADDR) begin
                                if (addr_hit) begin
                                    sda_oe_q <= 1'b1;
                                    is_rd_q  <= rx_sr_q[0];
                                    rd_stb_q <= rx_sr_q[0];
                                end
                            end else begin
                                sda_oe_q <= rx_accept;
                                case (wr_idx_q)
                                    3'd0: ptr_q <= rx_sr_q;
                                    3'd1: hi_q  <= rx_sr_q;
                                    3'd2: begin
                                        lo_q   <= rx_sr_q;
                                        pend_q <= ~chk_mode;
                                    end
                                    3'd3: begin
                                        pend_q   <= 1'b0;
                                        wr_stb_q <= csum_ok;
                                    end
                                    default: ;
                                endcase
                                if (wr_idx_q != IDX_MAX) begin
                                    wr_idx_q <= wr_idx_q + 3'd1;
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt_q <= '0;
                            if (is_rd_q) begin
                                tx_sr_q  <= rd_byte_sel(snap_q, 2'd0);
                                sda_oe_q <= ~snap_q[RS_DW-1];
                                rd_idx_q <= 2'd1;
                            end else begin
                                sda_oe_q <= 1'b0;
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            sda_oe_q <= 1'b0;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise && (bit_cnt_q != BYTE_BITS)) begin
                            bit_cnt_q <= bit_cnt_q + RS_BCNT_W'(1);
                        end else if (scl_fall) begin
                            if (bit_cnt_q == BYTE_BITS) begin
                                sda_oe_q  <= 1'b0;
                                bit_cnt_q <= '0;
                            end else begin
                                tx_sr_q  <= {tx_sr_q[RS_BYTE_W-2:0], 1'b0};
                                sda_oe_q <= ~tx_sr_q[RS_BYTE_W-2];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (mack_q) begin
                                tx_sr_q  <= next_byte;
                                sda_oe_q <= ~next_byte[RS_BYTE_W-1];
                                rd_idx_q <= rd_idx_q + 2'd1;
                            end else begin
                                sda_oe_q <= 1'b0;
                            end
                        end
                    end
                    ST_IDLE, ST_PARK: ;
                endcase
            end
        end
    end

    assign sda_oe  = sda_oe_q;
    assign wr_stb  = wr_stb_q;
    assign wr_addr = ptr_q;
    assign wr_data = {hi_q, lo_q};
    assign rd_stb  = rd_stb_q;
    assign rd_addr = ptr_q;

endmodule

// File: rtl/i2c_chk_regslave_sva.sv
module i2c_chk_regslave_sva (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic wr_stb,
    input logic rd_stb,
    input logic scl_fall,
    input logic start_det,
    input logic stop_det,
    input logic st_quiet
);

    AST_OE_RISE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall)); // R12

    AST_OE_FALL_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> $past(scl_fall || start_det || stop_det)); // R12

    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R3

    AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb); // R7

    AST_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        st_quiet |-> !sda_oe); // R9

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe); // R9

    AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe); // R11

endmodule

bind i2c_chk_regslave i2c_chk_regslave_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .st_quiet  (st_quiet)
);

// File: tb/sim_i2c_chk_regslave.sv
module sim_i2c_chk_regslave;

    localparam int         Q     = 12;
    localparam logic [6:0] DEV   = 7'b1110011;
    localparam int         LIMIT = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_bus;
    logic        sda_oe;
    logic        chk_mode = 1'b0;
    logic        wr_stb;
    logic [7:0]  wr_addr;
    logic [15:0] wr_data;
    logic        rd_stb;
    logic [7:0]  rd_addr;
    logic [15:0] rd_data;
    logic [15:0] rd_xor = 16'h0000;

    logic [15:0] regs     [256];
    logic [15:0] exp_regs [256];

    int n_chk = 0;
    int n_fail = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int oe_viol = 0;
    logic oe_prev = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;
    assign rd_data = regs[rd_addr] ^ rd_xor;

    i2c_chk_regslave u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .chk_mode (chk_mode),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_stb   (rd_stb),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    // Register bank model and strobe counters
    always @(posedge clk) begin
        if (wr_stb) begin
            regs[wr_addr] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end
        if (rd_stb) rd_cnt <= rd_cnt + 1;
        // R12: target must never change SDA while SCL is high
        if (sda_oe != oe_prev && scl_m) oe_viol <= oe_viol + 1;
        oe_prev <= sda_oe;
    end

    function automatic logic [7:0] csum(input logic [7:0] a, input logic [7:0] m, input logic [7:0] l);
        return 8'(9'h0FF + 9'(a) + 9'(m) + 9'(l));
    endfunction

    function automatic logic [31:0] echo4(input logic [15:0] v);
        return {v[15:8], v[7:0], ~v[15:8], ~v[7:0]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic write_bit(input logic b);
        sda_m = b;    wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic read_bit(output logic b);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        b = sda_bus;  wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) write_bit(d[i]);
        read_bit(b);
        ack = !b;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            read_bit(b);
            d[i] = b;
        end
        write_bit(mack ? 1'b0 : 1'b1);
    endtask

    task automatic rd_bytes(input int n, output logic [31:0] d);
        logic [7:0] b;
        d = '0;
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            d = {d[23:0], b};
        end
    endtask

    // kind: 0 no checksum, 1 correct checksum, 2 corrupted checksum
    task automatic do_write(input logic [7:0] a, input logic [7:0] m, input logic [7:0] l,
                            input int kind, output bit [4:0] acks);
        bit k;
        acks = '0;
        i2c_start();
        send_byte({DEV, 1'b0}, k); acks[4] = k;
        send_byte(a, k);           acks[3] = k;
        send_byte(m, k);           acks[2] = k;
        send_byte(l, k);           acks[1] = k;
        if (kind == 1) begin
            send_byte(csum(a, m, l), k); acks[0] = k;
        end else if (kind == 2) begin
            send_byte(csum(a, m, l) ^ 8'h01, k); acks[0] = k;
        end
    endtask

    task automatic read_cur(output bit ack, output logic [31:0] d);
        i2c_start();
        send_byte({DEV, 1'b1}, ack);
        rd_bytes(4, d);
        i2c_stop();
    endtask

    task automatic set_and_read(input logic [7:0] a, output logic [31:0] d);
        bit k;
        i2c_start();
        send_byte({DEV, 1'b0}, k);
        send_byte(a, k);
        read_cur(k, d);
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=%0d expected=0", LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit [4:0]    acks;
        bit          k;
        logic [31:0] d;
        int          w0, r0;
        int unsigned seed;
        seed = $urandom(32'h5EED_1234);
        for (int i = 0; i < 256; i++) begin
            regs[i] = 16'h0000;
            exp_regs[i] = 16'h0000;
        end
        repeat (10) @(negedge clk);
        check(sda_oe == 1'b0 && wr_stb == 1'b0 && rd_stb == 1'b0, "R9", "reset outputs",
              {29'd0, sda_oe, wr_stb, rd_stb}, 32'd0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(rd_addr == 8'h00, "R10", "pointer after reset", rd_addr, 0);

        // R2/R3 plain write, commit only at STOP
        w0 = wr_cnt;
        do_write(8'h12, 8'hA5, 8'h3C, 0, acks);
        check(acks[4:1] == 4'hF, "R2", "write byte acks", acks[4:1], 4'hF);
        check(wr_cnt == w0, "R3", "no commit before STOP", wr_cnt, w0);
        i2c_stop(); wq();
        check(wr_cnt == w0 + 1 && regs[8'h12] == 16'hA53C, "R3", "commit at STOP",
              {wr_cnt[15:0], regs[8'h12]}, {16'(w0 + 1), 16'hA53C});
        exp_regs[8'h12] = 16'hA53C;

        // R10/R7/R8 read of current pointer with no pointer byte
        r0 = rd_cnt;
        read_cur(k, d);
        check(k, "R7", "read address ack", k, 1);
        check(d == echo4(16'hA53C), "R10", "read uses persisting pointer", d, echo4(16'hA53C));
        check(rd_cnt == r0 + 1, "R7", "single sample per read", rd_cnt, r0 + 1);

        // R3 commit at repeated START, read back in the same transaction
        w0 = wr_cnt;
        do_write(8'h20, 8'h11, 8'h22, 0, acks);
        read_cur(k, d);
        check(d == echo4(16'h1122), "R3", "commit at repeated START", d, echo4(16'h1122));
        check(wr_cnt == w0 + 1, "R3", "one strobe", wr_cnt, w0 + 1);
        exp_regs[8'h20] = 16'h1122;

        // R4 good checksum commits during its ACK
        w0 = wr_cnt;
        do_write(8'h30, 8'hDE, 8'hAD, 1, acks);
        check(acks == 5'h1F, "R4", "checksum acked", acks, 5'h1F);
        check(wr_cnt == w0 + 1, "R4", "commit before STOP", wr_cnt, w0 + 1);
        i2c_stop(); wq();
        check(wr_cnt == w0 + 1, "R4", "no second commit at STOP", wr_cnt, w0 + 1);
        exp_regs[8'h30] = 16'hDEAD;

        // R5 bad checksum NACKed and discarded
        w0 = wr_cnt;
        do_write(8'h30, 8'h01, 8'h02, 2, acks);
        check(acks == 5'h1E, "R5", "bad checksum nacked", acks, 5'h1E);
        i2c_stop(); wq();
        check(wr_cnt == w0, "R5", "bad write discarded", wr_cnt, w0);
        set_and_read(8'h30, d);
        check(d == echo4(16'hDEAD), "R5", "register unchanged", d, echo4(16'hDEAD));

        // R6 mandatory checksum
        chk_mode = 1'b1;
        w0 = wr_cnt;
        do_write(8'h40, 8'h77, 8'h88, 0, acks);
        i2c_stop(); wq();
        check(wr_cnt == w0, "R6", "plain write ignored in checksum mode", wr_cnt, w0);
        set_and_read(8'h40, d);
        check(d == echo4(16'h0000), "R6", "register untouched", d, echo4(16'h0000));
        do_write(8'h40, 8'h77, 8'h88, 1, acks);
        i2c_stop(); wq();
        check(wr_cnt == w0 + 1 && regs[8'h40] == 16'h7788, "R6", "checked write committed",
              {wr_cnt[15:0], regs[8'h40]}, {16'(w0 + 1), 16'h7788});
        exp_regs[8'h40] = 16'h7788;
        chk_mode = 1'b0;

        // R8 snapshot holds although the register changes after sampling
        i2c_start();
        send_byte({DEV, 1'b0}, k);
        send_byte(8'h30, k);
        i2c_start();
        send_byte({DEV, 1'b1}, k);
        rd_xor = 16'h0F0F;
        rd_bytes(4, d);
        i2c_stop();
        rd_xor = 16'h0000;
        check(d == echo4(16'hDEAD), "R8", "inverted echo from snapshot", d, echo4(16'hDEAD));

        // R9 master NACK returns target to idle
        i2c_start();
        send_byte({DEV, 1'b1}, k);
        rd_bytes(1, d);
        check(d[7:0] == 8'hDE, "R7", "high byte first", d[7:0], 8'hDE);
        begin
            logic b;
            logic all_hi;
            all_hi = 1'b1;
            for (int i = 0; i < 9; i++) begin
                read_bit(b);
                all_hi = all_hi & b;
            end
            check(all_hi == 1'b1, "R9", "SDA released after NACK", all_hi, 1);
        end
        i2c_stop();

        // R1 foreign addresses
        w0 = wr_cnt; r0 = rd_cnt;
        i2c_start();
        send_byte({7'b1110010, 1'b0}, k);
        check(!k, "R1", "foreign write address nacked", k, 0);
        send_byte(8'h30, k);
        check(!k, "R1", "later byte not acked", k, 0);
        i2c_stop();
        i2c_start();
        send_byte({7'b0110011, 1'b1}, k);
        check(!k, "R1", "foreign read address nacked", k, 0);
        i2c_stop(); wq();
        check(wr_cnt == w0 && rd_cnt == r0, "R1", "no strobes",
              {wr_cnt[15:0], rd_cnt[15:0]}, {w0[15:0], r0[15:0]});

        // R11 START aborts mid-write and mid-byte
        w0 = wr_cnt;
        i2c_start();
        send_byte({DEV, 1'b0}, k);
        send_byte(8'h50, k);
        send_byte(8'h99, k);
        read_cur(k, d);
        check(wr_cnt == w0, "R11", "aborted write not committed", wr_cnt, w0);
        check(d == echo4(16'h0000), "R11", "read after abort", d, echo4(16'h0000));
        i2c_start();
        send_byte({DEV, 1'b0}, k);
        write_bit(1'b1); write_bit(1'b0); write_bit(1'b1);
        i2c_start();
        send_byte({DEV, 1'b1}, k);
        check(k, "R11", "address accepted after mid-byte START", k, 1);
        rd_bytes(1, d);
        i2c_stop();

        // Random writes in all three forms and both modes, each read back
        for (int it = 0; it < 10; it++) begin
            logic [7:0] a, m, l;
            int kind;
            bit cm, commit;
            a = 8'h60 + 8'($urandom % 8);
            m = 8'($urandom);
            l = 8'($urandom);
            kind = int'($urandom % 3);
            cm = 1'($urandom);
            chk_mode = cm;
            commit = (kind == 1) || (kind == 0 && !cm);
            do_write(a, m, l, kind, acks);
            i2c_stop();
            if (kind != 0)
                check(acks[0] == (kind == 1), kind == 1 ? "R4" : "R5", "random checksum ack",
                      acks[0], (kind == 1));
            if (commit) exp_regs[a] = {m, l};
            set_and_read(a, d);
            check(d == echo4(exp_regs[a]), cm ? "R6" : "R3", "random read back",
                  d, echo4(exp_regs[a]));
        end
        chk_mode = 1'b0;

        check(oe_viol == 0, "R12", "SDA changed while SCL high", oe_viol, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule